// File: doc/BRIEF.md
# Dual-Width Condition-Code ALU

This block is the integer arithmetic and logic stage of a 64-bit execution pipe. It is purely combinational. It takes an operation code, two 64-bit operands and the carry flag of the narrow (32-bit) flag set. In the same pass it returns a 64-bit result and two flag sets. The narrow set is derived from the low 32 bits of the computation and the wide set from all 64 bits, so a later branch or conditional move can test either width without recomputing anything.

The operations are addition and subtraction, each with or without the incoming carry; the three logical operations and their forms with the second operand inverted; and tagged addition and subtraction. Tagged arithmetic treats the low two bits of each operand as a type tag. A nonzero tag counts as a narrow overflow. The trapping forms turn that overflow into a trap request and suppress the flag write. The flag-write enable tells the surrounding pipe whether the flag sets produced in this pass should be committed.

The block has no clock and holds no state. The house state-machine pattern therefore reduces to a single decode `unique case` over an enumerated function code. That decode drives the arithmetic unit, the logic unit and the per-width flag generator.

Top module: `cc_alu`

## Requirements
- R1: Opcode bits [3:0] select the function: 0 add, 1 subtract, 2 add with carry, 3 subtract with carry, 4 and, 5 or, 6 xor, 7 and with inverted B, 8 or with inverted B, 9 xnor, 10 tagged add, 11 tagged subtract, 12 trapping tagged add, 13 trapping tagged subtract. Add returns A+B modulo 2^64. The narrow carry (flag bit 0) is the carry out of bit 31 and the wide carry is the carry out of bit 63.
- R2: For add-type operations, flag bit 1 (V) is set at a width when A and B have equal sign bits at that width and the result's sign bit differs from them.
- R3: Subtract returns A-B modulo 2^64. Its carry flags report a borrow, which is the inverse of the carry out of A + ~B + 1 at bit 31 and at bit 63.
- R4: For subtract-type operations, V is set at a width when A and B differ in sign at that width and the result sign differs from A's sign.
- R5: Add with carry returns A+B+carry_in_i. Subtract with carry returns A-B-carry_in_i, and its flags report borrow and overflow as in R3/R4 for that full computation.
- R6: The logical functions return A&B, A|B, A^B, A&~B, A|~B and ~(A^B).
- R7: For logical functions, V and C are 0 in both flag sets.
- R8: Each flag set is {N,Z,V,C} in bits [3:0]. N is the top bit of the result at that width and Z is set when the result is zero over that width.
- R9: Tagged add and subtract behave as add and subtract. The narrow V is additionally set when bits 1:0 of A or of B are nonzero. The wide V keeps only the arithmetic rule.
- R10: The trapping tagged functions assert tag_trap_o exactly when the narrow V of R9 is set, and in that case cc_we_o is 0.
- R11: cc_we_o is 1 when opcode bit 4 is set or the function is tagged, unless R10 traps. Function codes 14 and 15 give result 0, cc_we_o 0 and no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Bit 4 requests a flag write; bits 3:0 select the function |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| carry_in_i | input | 1 | Current narrow carry flag, used by the with-carry functions |
| result_o | output | 64 | Operation result |
| cc_lo_o | output | 4 | Narrow flag set {N,Z,V,C} from bits 31:0 |
| cc_hi_o | output | 4 | Wide flag set {N,Z,V,C} from bits 63:0 |
| cc_we_o | output | 1 | Commit the flag sets |
| tag_trap_o | output | 1 | Tag-overflow trap request |

## Verification
The bench targets operands whose low word wraps while the high word does not. A design that took the narrow carry from the wrong bit, or derived the narrow zero flag from the full word, would report the wrong narrow C or Z on those operands. Subtraction of equal values and 0-1 separate borrow from raw carry out: a block that exported the raw carry would invert every subtract C flag. With-carry cases drive both values of carry_in_i. Tagged cases put nonzero tag bits on operands whose sums do not overflow, which catches a narrow V that ignores the tag or a wide V that wrongly includes it. Trapping cases confirm that a trap withholds the flag write.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

    localparam int OP_W   = 5;
    localparam int FUNC_W = 4;
    localparam int CC_W   = 4;

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD    = 4'd0,
        FN_SUB    = 4'd1,
        FN_ADDC   = 4'd2,
        FN_SUBC   = 4'd3,
        FN_AND    = 4'd4,
        FN_OR     = 4'd5,
        FN_XOR    = 4'd6,
        FN_ANDN   = 4'd7,
        FN_ORN    = 4'd8,
        FN_XNOR   = 4'd9,
        FN_TADD   = 4'd10,
        FN_TSUB   = 4'd11,
        FN_TADDT  = 4'd12,
        FN_TSUBT  = 4'd13,
        FN_RSV0   = 4'd14,
        FN_RSV1   = 4'd15
    } alu_func_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_kind_e;

    typedef enum logic [1:0] {
        CI_ZERO = 2'd0,
        CI_ONE  = 2'd1,
        CI_FLAG = 2'd2,
        CI_NFLG = 2'd3
    } cin_sel_e;

endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
    parameter int DATA_W = 64,
    parameter int LO_W   = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              invert_b_i,
    input  logic              cbit_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] bx_o,
    output logic [1:0]        cout_o
);
    localparam int HI_W = DATA_W - LO_W;

    logic [LO_W:0] lo_sum;
    logic [HI_W:0] hi_sum;

    always_comb begin
        bx_o   = invert_b_i ? ~b_i : b_i;
        lo_sum = {1'b0, a_i[LO_W-1:0]} + {1'b0, bx_o[LO_W-1:0]} + {{LO_W{1'b0}}, cbit_i};
        hi_sum = {1'b0, a_i[DATA_W-1:LO_W]} + {1'b0, bx_o[DATA_W-1:LO_W]}
               + {{HI_W{1'b0}}, lo_sum[LO_W]};
        sum_o  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
        cout_o = {hi_sum[HI_W], lo_sum[LO_W]};
    end
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic_kind_e       kind_i,
    input  logic              invert_b_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] bsel;

    always_comb begin
        bsel = invert_b_i ? ~b_i : b_i;
        unique case (kind_i)
            LG_AND:  res_o = a_i & bsel;
            LG_OR:   res_o = a_i | bsel;
            LG_XOR:  res_o = a_i ^ bsel;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LO_W   = 32
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] bx_i,
    input  logic              arith_i,
    input  logic [1:0]        carry_i,
    input  logic              tag_ovf_i,
    output logic [CC_W-1:0]   cc_lo_o,
    output logic [CC_W-1:0]   cc_hi_o
);
    logic [1:0][CC_W-1:0] cc;

    for (genvar k = 0; k < 2; k++) begin : g_width
        localparam int WK = (k == 0) ? LO_W : DATA_W;
        logic n_f, z_f, v_f, extra;
        assign n_f   = res_i[WK-1];
        assign z_f   = ~|res_i[WK-1:0];
        assign extra = (k == 0) ? tag_ovf_i : 1'b0;
        assign v_f   = (arith_i && (a_i[WK-1] == bx_i[WK-1]) && (res_i[WK-1] != a_i[WK-1]))
                     || extra;
        assign cc[k] = {n_f, z_f, v_f, carry_i[k]};
    end

    assign cc_lo_o = cc[0];
    assign cc_hi_o = cc[1];
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LO_W   = 32
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_in_i,
    output logic [DATA_W-1:0] result_o,
    output logic [CC_W-1:0]   cc_lo_o,
    output logic [CC_W-1:0]   cc_hi_o,
    output logic              cc_we_o,
    output logic              tag_trap_o
);
    alu_func_e   func;
    logic        is_arith, is_sub, is_tag, is_trapping, is_logic, neg_b;
    cin_sel_e    cin_sel;
    logic_kind_e lkind;
    logic        cbit, tag_ovf;
    logic [DATA_W-1:0] sum, bx, lres;
    logic [1:0]  cout, carry_flags;
    logic [CC_W-1:0] cc_lo_raw;

    assign func = alu_func_e'(op_i[FUNC_W-1:0]);

    // Decode: one named branch per function code.
    always_comb begin
        is_arith    = 1'b0;
        is_sub      = 1'b0;
        is_tag      = 1'b0;
        is_trapping = 1'b0;
        is_logic    = 1'b0;
        neg_b       = 1'b0;
        cin_sel     = CI_ZERO;
        lkind       = LG_AND;
        unique case (func)
            FN_ADD:   is_arith = 1'b1;
            FN_SUB:   begin is_arith = 1'b1; is_sub = 1'b1; cin_sel = CI_ONE; end
            FN_ADDC:  begin is_arith = 1'b1; cin_sel = CI_FLAG; end
            FN_SUBC:  begin is_arith = 1'b1; is_sub = 1'b1; cin_sel = CI_NFLG; end
            FN_AND:   begin is_logic = 1'b1; lkind = LG_AND; end
            FN_OR:    begin is_logic = 1'b1; lkind = LG_OR; end
            FN_XOR:   begin is_logic = 1'b1; lkind = LG_XOR; end
            FN_ANDN:  begin is_logic = 1'b1; lkind = LG_AND; neg_b = 1'b1; end
            FN_ORN:   begin is_logic = 1'b1; lkind = LG_OR;  neg_b = 1'b1; end
            FN_XNOR:  begin is_logic = 1'b1; lkind = LG_XOR; neg_b = 1'b1; end
            FN_TADD:  begin is_arith = 1'b1; is_tag = 1'b1; end
            FN_TSUB:  begin is_arith = 1'b1; is_tag = 1'b1; is_sub = 1'b1; cin_sel = CI_ONE; end
            FN_TADDT: begin is_arith = 1'b1; is_tag = 1'b1; is_trapping = 1'b1; end
            FN_TSUBT: begin is_arith = 1'b1; is_tag = 1'b1; is_trapping = 1'b1;
                            is_sub = 1'b1; cin_sel = CI_ONE; end
            FN_RSV0, FN_RSV1: ;
            default: ;
        endcase
    end

    always_comb begin
        unique case (cin_sel)
            CI_ZERO: cbit = 1'b0;
            CI_ONE:  cbit = 1'b1;
            CI_FLAG: cbit = carry_in_i;
            CI_NFLG: cbit = ~carry_in_i;
            default: cbit = 1'b0;
        endcase
    end

    cc_alu_addsub #(.DATA_W(DATA_W), .LO_W(LO_W)) u_addsub (
        .a_i        (a_i),
        .b_i        (b_i),
        .invert_b_i (is_sub),
        .cbit_i     (cbit),
        .sum_o      (sum),
        .bx_o       (bx),
        .cout_o     (cout)
    );

    cc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i        (a_i),
        .b_i        (b_i),
        .kind_i     (lkind),
        .invert_b_i (neg_b),
        .res_o      (lres)
    );

    always_comb begin
        if (is_arith)      result_o = sum;
        else if (is_logic) result_o = lres;
        else               result_o = '0;
        carry_flags = is_arith ? (cout ^ {2{is_sub}}) : 2'b00;
        tag_ovf     = is_tag && ((|a_i[1:0]) || (|b_i[1:0]));
    end

    cc_alu_flags #(.DATA_W(DATA_W), .LO_W(LO_W)) u_flags (
        .res_i     (result_o),
        .a_i       (a_i),
        .bx_i      (bx),
        .arith_i   (is_arith),
        .carry_i   (carry_flags),
        .tag_ovf_i (tag_ovf),
        .cc_lo_o   (cc_lo_raw),
        .cc_hi_o   (cc_hi_o)
    );

    assign cc_lo_o    = cc_lo_raw;
    assign tag_trap_o = is_trapping && cc_lo_raw[1];
    assign cc_we_o    = (op_i[OP_W-1] || is_tag) && !tag_trap_o && (is_arith || is_logic);
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] result_o,
    input logic [CC_W-1:0]   cc_lo_o,
    input logic [CC_W-1:0]   cc_hi_o,
    input logic              cc_we_o,
    input logic              tag_trap_o
);
    logic [FUNC_W-1:0] fn;
    assign fn = op_i[FUNC_W-1:0];

    always_comb begin
        // R10: a trap suppresses the flag write
        p_trap_no_we_r10: assert (!(tag_trap_o && cc_we_o));
        // R10: a trap only comes from a trapping tagged code with narrow V set
        p_trap_source_r10: assert (!tag_trap_o || ((fn == 4'd12 || fn == 4'd13) && cc_lo_o[1]));
        // R7: logical functions leave V and C clear at both widths
        p_logic_vc_r7: assert (!(fn >= 4'd4 && fn <= 4'd9) ||
                               (cc_lo_o[1:0] == 2'b00 && cc_hi_o[1:0] == 2'b00));
        // R8: a zero wide result implies a zero narrow result
        p_zero_nest_r8: assert (!cc_hi_o[2] || cc_lo_o[2]);
        // R9: nonzero tag bits force narrow overflow on tagged codes
        p_tag_bits_r9: assert (!(fn >= 4'd10 && fn <= 4'd13 && ((|a_i[1:0]) || (|b_i[1:0]))) ||
                               cc_lo_o[1]);
        // R11: reserved codes produce nothing
        p_reserved_r11: assert (!(fn >= 4'd14) ||
                                (result_o == '0 && !cc_we_o && !tag_trap_o));
    end
endmodule

bind cc_alu cc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .op_i       (op_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .result_o   (result_o),
    .cc_lo_o    (cc_lo_o),
    .cc_hi_o    (cc_hi_o),
    .cc_we_o    (cc_we_o),
    .tag_trap_o (tag_trap_o)
);

// File: tb/cc_alu_tb.sv
module cc_alu_tb;
    logic        clk = 1'b0;
    logic [4:0]  op;
    logic [63:0] a, b;
    logic        cin;
    logic [63:0] res;
    logic [3:0]  cc_lo, cc_hi;
    logic        we, trap;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cc_alu u_dut (
        .op_i       (op),
        .a_i        (a),
        .b_i        (b),
        .carry_in_i (cin),
        .result_o   (res),
        .cc_lo_o    (cc_lo),
        .cc_hi_o    (cc_hi),
        .cc_we_o    (we),
        .tag_trap_o (trap)
    );

    logic [63:0] e_res;
    logic [3:0]  e_lo, e_hi;
    logic        e_we, e_trap;
    string       t_res, t_cc;

    task automatic model(input logic [4:0] o, input logic [63:0] x, input logic [63:0] y,
                         input logic ci);
        logic [3:0] f;
        logic sub, arith, tag, trp, logi, cb, c32, c64, v32, v64;
        logic [63:0] yb;
        logic [32:0] lo;
        logic [64:0] full;
        f = o[3:0];
        arith = (f <= 4'd3) || (f >= 4'd10 && f <= 4'd13);
        logi  = (f >= 4'd4 && f <= 4'd9);
        tag   = (f >= 4'd10 && f <= 4'd13);
        trp   = (f == 4'd12 || f == 4'd13);
        sub   = (f == 4'd1 || f == 4'd3 || f == 4'd11 || f == 4'd13);
        cb    = (f == 4'd2) ? ci : (f == 4'd3) ? ~ci : sub;
        yb    = sub ? ~y : y;
        lo    = {1'b0, x[31:0]} + {1'b0, yb[31:0]} + {32'd0, cb};
        full  = {1'b0, x} + {1'b0, yb} + {64'd0, cb};
        c32 = 1'b0; c64 = 1'b0; v32 = 1'b0; v64 = 1'b0;
        if (arith) begin
            e_res = full[63:0];
            c32 = lo[32] ^ sub;
            c64 = full[64] ^ sub;
            v32 = (x[31] == yb[31]) && (e_res[31] != x[31]);
            v64 = (x[63] == yb[63]) && (e_res[63] != x[63]);
            if (tag && (x[1:0] != 2'b00 || y[1:0] != 2'b00)) v32 = 1'b1;
        end else if (logi) begin
            case (f)
                4'd4: e_res = x & y;
                4'd5: e_res = x | y;
                4'd6: e_res = x ^ y;
                4'd7: e_res = x & ~y;
                4'd8: e_res = x | ~y;
                default: e_res = ~(x ^ y);
            endcase
        end else begin
            e_res = 64'd0;
        end
        e_lo   = {e_res[31], e_res[31:0] == 32'd0, v32, c32};
        e_hi   = {e_res[63], e_res == 64'd0, v64, c64};
        e_trap = trp && v32;
        e_we   = (arith || logi) && (o[4] || tag) && !e_trap;
        if (f == 4'd0) begin t_res = "R1"; t_cc = "R2"; end
        else if (f == 4'd1) begin t_res = "R3"; t_cc = "R4"; end
        else if (f <= 4'd3) begin t_res = "R5"; t_cc = "R5"; end
        else if (logi) begin t_res = "R6"; t_cc = "R7"; end
        else if (tag) begin t_res = "R9"; t_cc = "R9"; end
        else begin t_res = "R11"; t_cc = "R8"; end
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (op=%h a=%h b=%h cin=%b)",
                     tag, what, act, exp, op, a, b, cin);
        end
    endtask

    task automatic apply(input logic [4:0] o, input logic [63:0] x, input logic [63:0] y,
                         input logic ci, input string ztag);
        @(negedge clk);
        op = o; a = x; b = y; cin = ci;
        #1;
        model(o, x, y, ci);
        chk(t_res, "result", res, e_res);
        chk((ztag != "") ? ztag : t_cc, "cc_lo", {60'd0, cc_lo}, {60'd0, e_lo});
        chk((ztag != "") ? ztag : t_cc, "cc_hi", {60'd0, cc_hi}, {60'd0, e_hi});
        chk("R11", "cc_we", {63'd0, we}, {63'd0, e_we});
        chk("R10", "trap", {63'd0, trap}, {63'd0, e_trap});
    endtask

    initial begin
        op = 5'd0; a = '0; b = '0; cin = 1'b0;
        // R8: zero add yields both Z set, N clear
        apply(5'h10, 64'd0, 64'd0, 1'b0, "R8");
        // R1: narrow carry without wide carry; narrow Z without wide Z (R8)
        apply(5'h10, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, "R8");
        apply(5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "");
        // R2: narrow and wide overflow
        apply(5'h10, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, "R2");
        apply(5'h10, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R2");
        // R3: equal operands give no borrow; 0-1 borrows at both widths
        apply(5'h11, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b0, "R3");
        apply(5'h11, 64'd0, 64'd1, 1'b0, "R3");
        // R4: signed overflow on subtract
        apply(5'h11, 64'h8000_0000_8000_0000, 64'd1, 1'b0, "R4");
        // R5: carry in both ways
        apply(5'h12, 64'h0000_0000_FFFF_FFFE, 64'd1, 1'b1, "R5");
        apply(5'h13, 64'd1, 64'd0, 1'b1, "R5");
        apply(5'h13, 64'd0, 64'd0, 1'b1, "R5");
        // R6/R7: xnor of equal operands; and-not
        apply(5'h19, 64'hDEAD_BEEF_0000_1111, 64'hDEAD_BEEF_0000_1111, 1'b0, "R7");
        apply(5'h17, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b0, "R7");
        // R9: tag bits alone set narrow V only
        apply(5'h0A, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_0010, 1'b0, "R9");
        apply(5'h0B, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0002, 1'b0, "R9");
        // R10: trapping variants, with and without overflow
        apply(5'h1C, 64'h0000_0000_0000_0001, 64'd4, 1'b0, "R10");
        apply(5'h1D, 64'h0000_0000_0000_0040, 64'd4, 1'b0, "R10");
        apply(5'h0C, 64'h0000_0000_7FFF_FFFC, 64'd4, 1'b0, "R10");
        // R11: write enable follows bit 4; reserved codes do nothing
        apply(5'h00, 64'd5, 64'd6, 1'b0, "");
        apply(5'h1E, 64'hFFFF, 64'h1, 1'b1, "R11");
        apply(5'h0F, 64'hFFFF, 64'h1, 1'b1, "R11");
        // Constrained random mix with biased operands
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  ro;
            logic [63:0] ra, rb;
            ro = 5'($urandom_range(0, 31));
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            case ($urandom_range(0, 3))
                0: rb[1:0] = 2'b00;
                1: ra[31:0] = 32'hFFFF_FFFF;
                2: rb = ra;
                default: ;
            endcase
            apply(ro, ra, rb, 1'($urandom_range(0, 1)), "");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule